// File: doc/BRIEF.md
# Extended-Precision Operand Classifier and NaN Propagator

This block takes one or two floating-point operands in an extended layout (sign bit, biased exponent, fraction with an explicit integer bit) and produces, one clock after a start strobe, a registered result with its four condition flags: negative, zero, infinity and not-a-number. It resolves the not-a-number pre-check of a floating-point unit. When an operand is a NaN it chooses the operand that propagates and makes it quiet. It also reports whether a signaling NaN was seen.

When no NaN is involved, the block executes the cheap operations that need no adder or rounder: move, test, absolute value, negate and get-exponent. Get-exponent returns the unbiased exponent of the source as a signed integer, normalized back into the extended layout. Infinities and zeros are special cases for this operation. A surrounding unit drives the op code and a dyadic qualifier and pulses start. It then takes the result on the done pulse and uses the write-enable output to decide whether to store it.

Top module: `xfp_classify_unit`

## Requirements
- R1: After reset, done, result, all four flags, wr_en, snan and operr are zero.
- R2: done is high in exactly the cycle after a cycle with start high. The outputs change only in that cycle and hold their values otherwise.
- R3: flag_n equals the result sign bit. flag_z is high when the result exponent and the whole fraction, integer bit included, are zero.
- R4: flag_inf is high when the result exponent is all ones and fraction bits [FRAC_W-2:0] are zero. flag_nan is high when the exponent is all ones and those bits are nonzero. The integer bit (fraction MSB) is ignored.
- R5: If the source is a NaN, or dyadic is high and the destination is a NaN, the result is the destination when dyadic is high and the destination is a NaN, and the source otherwise. When dyadic is low the destination has no effect on any output.
- R6: A propagated NaN leaves with fraction bit FRAC_W-2 set. snan is high when an examined NaN operand (the source, and the destination when dyadic) had that bit clear.
- R7: With no NaN involved, op 0 (move) returns the source, op 2 (abs) returns it with the sign cleared, op 3 (negate) returns it with the sign inverted, and ops 5 to 7 act as move.
- R8: wr_en is low for op 1 (test) and high for every other op. For op 1 the result and flags are those of a move.
- R9: Op 4 (get-exponent) on an infinity raises operr and returns the default NaN: sign 1, exponent all ones, top two fraction bits set, other bits clear.
- R10: Op 4 on a zero of either sign returns that zero unchanged.
- R11: Op 4 on any other non-NaN value returns the biased exponent minus the bias, 2^(EXP_W-1)-1, as an exact signed value in extended form. The value is normalized so that the integer bit is set, and the exponent is the bias plus the position of the magnitude MSB. A zero difference gives +0.
- R12: operr is high only in the infinity case of R9. snan is low whenever no NaN propagates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation this cycle |
| op | input | 3 | Operation select: 0 move, 1 test, 2 abs, 3 negate, 4 get-exponent, 5..7 move |
| dyadic | input | 1 | Destination takes part in the NaN check |
| src | input | 1+EXP_W+FRAC_W | Source operand |
| dst | input | 1+EXP_W+FRAC_W | Destination operand |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 1+EXP_W+FRAC_W | Registered result |
| wr_en | output | 1 | Result is to be written back |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| flag_inf | output | 1 | Result infinite |
| flag_nan | output | 1 | Result not-a-number |
| snan | output | 1 | Signaling NaN among examined operands |
| operr | output | 1 | Operand error from get-exponent |

## Verification
The bench builds the block with EXP_W=4 and FRAC_W=6, an 11-bit format with a bias of 7. At that size every source encoding can be run under every op code. The sweep covers every exponent, including denormals, the bias point where get-exponent yields +0, and the all-ones exponent with the integer bit both set and clear. A second sweep pairs every source with a set of quiet, signaling, infinite and ordinary destinations in dyadic mode to exercise the choice between the two NaNs. The first sweep drives destinations that are deliberately NaN-heavy with dyadic low, to show they are ignored.

// File: rtl/xfp_pkg.sv
package xfp_pkg;

    typedef enum logic [2:0] {
        XOP_MOVE   = 3'd0,
        XOP_TEST   = 3'd1,
        XOP_ABS    = 3'd2,
        XOP_NEG    = 3'd3,
        XOP_GETEXP = 3'd4
    } xop_e;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_inf;
        logic is_nan;
        logic is_snan;
    } xclass_t;

    function automatic int unsigned exp_bias(input int unsigned ew);
        return (1 << (ew - 1)) - 1;
    endfunction

endpackage

// File: rtl/xfp_operand_class.sv
module xfp_operand_class
    import xfp_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int FRAC_W = 64
) (
    input  logic [EXP_W+FRAC_W:0] val,
    output xclass_t               cls
);
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic              ex_top;
    logic              low_nz;

    always_comb begin
        ex          = val[FRAC_W +: EXP_W];
        fr          = val[FRAC_W-1:0];
        ex_top      = &ex;
        low_nz      = |fr[FRAC_W-2:0];
        cls.sign    = val[EXP_W+FRAC_W];
        cls.is_zero = (ex == '0) && (fr == '0);
        cls.is_inf  = ex_top && !low_nz;
        cls.is_nan  = ex_top && low_nz;
        cls.is_snan = ex_top && low_nz && !fr[FRAC_W-2];
    end
endmodule

// File: rtl/xfp_nan_pick.sv
module xfp_nan_pick
    import xfp_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int FRAC_W = 64
) (
    input  logic [EXP_W+FRAC_W:0] src,
    input  logic [EXP_W+FRAC_W:0] dst,
    input  xclass_t               src_cls,
    input  xclass_t               dst_cls,
    input  logic                  dyadic,
    output logic                  take,
    output logic [EXP_W+FRAC_W:0] value,
    output logic                  signaling
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 2);

    logic src_hit;
    logic dst_hit;

    always_comb begin
        src_hit   = src_cls.is_nan;
        dst_hit   = dyadic && dst_cls.is_nan;
        take      = src_hit || dst_hit;
        value     = (dst_hit ? dst : src) | QUIET_BIT;
        signaling = (src_hit && src_cls.is_snan) || (dst_hit && dst_cls.is_snan);
    end
endmodule

// File: rtl/xfp_getexp.sv
module xfp_getexp
    import xfp_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int FRAC_W = 64
) (
    input  logic [EXP_W+FRAC_W:0] src,
    input  xclass_t               src_cls,
    output logic [EXP_W+FRAC_W:0] value,
    output logic                  operr
);
    localparam int IW   = EXP_W + 1;
    localparam int BIAS = int'(exp_bias(EXP_W));

    logic signed [IW-1:0] unb;
    logic [IW-1:0]        mag;
    logic [EXP_W-1:0]     pos;
    logic [EXP_W-1:0]     exp_n;
    logic [FRAC_W-1:0]    frac_n;
    int                   sh;

    always_comb begin
        unb = $signed({1'b0, src[FRAC_W +: EXP_W]}) - $signed(IW'(BIAS));
        mag = unb[IW-1] ? IW'(-unb) : IW'(unb);
        pos = '0;
        for (int k = 0; k < IW; k++) begin
            if (mag[k]) pos = EXP_W'(k);
        end
        sh     = FRAC_W - 1 - int'(pos);
        frac_n = FRAC_W'(mag) << sh;
        exp_n  = EXP_W'(BIAS) + pos;

        operr = 1'b0;
        if (src_cls.is_inf) begin
            operr = 1'b1;
            value = {1'b1, {EXP_W{1'b1}}, 2'b11, {(FRAC_W-2){1'b0}}};
        end else if (src_cls.is_zero) begin
            value = src;
        end else if (unb == '0) begin
            value = '0;
        end else begin
            value = {unb[IW-1], exp_n, frac_n};
        end
    end
endmodule

// File: rtl/xfp_classify_unit.sv
module xfp_classify_unit
    import xfp_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int FRAC_W = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [2:0]            op,
    input  logic                  dyadic,
    input  logic [EXP_W+FRAC_W:0] src,
    input  logic [EXP_W+FRAC_W:0] dst,
    output logic                  done,
    output logic [EXP_W+FRAC_W:0] result,
    output logic                  wr_en,
    output logic                  flag_n,
    output logic                  flag_z,
    output logic                  flag_inf,
    output logic                  flag_nan,
    output logic                  snan,
    output logic                  operr
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [W-1:0] opnd [2];
    xclass_t      opnd_cls [2];

    assign opnd[0] = src;
    assign opnd[1] = dst;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        xfp_operand_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val (opnd[g]),
            .cls (opnd_cls[g])
        );
    end

    logic         pick_take;
    logic [W-1:0] pick_val;
    logic         pick_sig;

    xfp_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pick (
        .src       (src),
        .dst       (dst),
        .src_cls   (opnd_cls[0]),
        .dst_cls   (opnd_cls[1]),
        .dyadic    (dyadic),
        .take      (pick_take),
        .value     (pick_val),
        .signaling (pick_sig)
    );

    logic [W-1:0] ge_val;
    logic         ge_operr;

    xfp_getexp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_getexp (
        .src     (src),
        .src_cls (opnd_cls[0]),
        .value   (ge_val),
        .operr   (ge_operr)
    );

    logic [W-1:0] nxt_res;
    logic         nxt_operr;
    logic         nxt_snan;
    xclass_t      res_cls;

    always_comb begin
        nxt_res   = src;
        nxt_operr = 1'b0;
        nxt_snan  = 1'b0;
        if (pick_take) begin
            nxt_res  = pick_val;
            nxt_snan = pick_sig;
        end else begin
            case (op)
                XOP_ABS:    nxt_res = {1'b0, src[W-2:0]};
                XOP_NEG:    nxt_res = {~src[W-1], src[W-2:0]};
                XOP_GETEXP: begin
                    nxt_res   = ge_val;
                    nxt_operr = ge_operr;
                end
                default:    nxt_res = src;
            endcase
        end
    end

    xfp_operand_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_res_cls (
        .val (nxt_res),
        .cls (res_cls)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            result   <= '0;
            wr_en    <= 1'b0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
            flag_inf <= 1'b0;
            flag_nan <= 1'b0;
            snan     <= 1'b0;
            operr    <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                result   <= nxt_res;
                wr_en    <= (op != XOP_TEST);
                flag_n   <= res_cls.sign;
                flag_z   <= res_cls.is_zero;
                flag_inf <= res_cls.is_inf;
                flag_nan <= res_cls.is_nan;
                snan     <= nxt_snan;
                operr    <= nxt_operr;
            end
        end
    end
endmodule

// File: rtl/xfp_classify_chk.sv
module xfp_classify_chk #(
    parameter int EXP_W  = 15,
    parameter int FRAC_W = 64
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic [2:0]            op,
    input logic                  dyadic,
    input logic [EXP_W+FRAC_W:0] src,
    input logic [EXP_W+FRAC_W:0] dst,
    input logic                  done,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  wr_en,
    input logic                  flag_n,
    input logic                  flag_z,
    input logic                  flag_inf,
    input logic                  flag_nan,
    input logic                  snan,
    input logic                  operr
);
    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result) && !done));

    // R4
    flag_class_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot0({flag_z, flag_inf, flag_nan}));

    // R6
    nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (done && flag_nan) |-> result[FRAC_W-2]);

    // R7
    abs_positive_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd2 && !dyadic && src[FRAC_W +: EXP_W] != '1) |=> !flag_n);

    // R8
    test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd1) |=> !wr_en);

    // R10
    getexp_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd4 && src[EXP_W+FRAC_W-1:0] == '0) |=> (result == $past(src)));

    // R12
    operr_only_getexp_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op != 3'd4) |=> !operr);
endmodule

bind xfp_classify_unit xfp_classify_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_xfp_chk (.*);

// File: tb/test_xfp_classify_unit.sv
module test_xfp_classify_unit;
    localparam int EW = 4;
    localparam int FW = 6;
    localparam int W  = 1 + EW + FW;
    localparam int BIAS = 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [2:0]   op = '0;
    logic         dyadic = 1'b0;
    logic [W-1:0] src = '0;
    logic [W-1:0] dst = '0;
    logic         done, wr_en, flag_n, flag_z, flag_inf, flag_nan, snan, operr;
    logic [W-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xfp_classify_unit #(.EXP_W(EW), .FRAC_W(FW)) i_xfp_classify_unit (
        .clk(clk), .rst(rst), .start(start), .op(op), .dyadic(dyadic),
        .src(src), .dst(dst), .done(done), .result(result), .wr_en(wr_en),
        .flag_n(flag_n), .flag_z(flag_z), .flag_inf(flag_inf), .flag_nan(flag_nan),
        .snan(snan), .operr(operr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic bit is_nan_v(input logic [W-1:0] x);
        return (x[W-2:FW] == {EW{1'b1}}) && (x[FW-2:0] != '0);
    endfunction

    // Expected result value from the requirements.
    function automatic logic [W-1:0] exp_result(input int o, input bit dy,
                                               input logic [W-1:0] s, input logic [W-1:0] d,
                                               output string tag, output bit e_snan,
                                               output bit e_operr);
        logic [W-1:0] r;
        int e, m, p;
        e_snan  = 0;
        e_operr = 0;
        if (is_nan_v(s) || (dy && is_nan_v(d))) begin
            tag = "R5";
            r = (dy && is_nan_v(d)) ? d : s;
            r[FW-2] = 1'b1;
            e_snan = (is_nan_v(s) && !s[FW-2]) || (dy && is_nan_v(d) && !d[FW-2]);
        end else if (o == 2) begin
            tag = "R7"; r = {1'b0, s[W-2:0]};
        end else if (o == 3) begin
            tag = "R7"; r = {~s[W-1], s[W-2:0]};
        end else if (o == 4) begin
            if (s[W-2:FW] == {EW{1'b1}}) begin
                tag = "R9"; e_operr = 1;
                r = {1'b1, {EW{1'b1}}, 2'b11, {(FW-2){1'b0}}};
            end else if (s[W-2:0] == '0) begin
                tag = "R10"; r = s;
            end else begin
                tag = "R11";
                e = int'(s[W-2:FW]) - BIAS;
                if (e == 0) r = '0;
                else begin
                    m = (e < 0) ? -e : e;
                    p = 0;
                    while ((1 << (p + 1)) <= m) p++;
                    r = {(e < 0), EW'(BIAS + p), FW'(m << (FW - 1 - p))};
                end
            end
        end else if (o == 1) begin
            tag = "R8"; r = s;
        end else begin
            tag = "R7"; r = s;
        end
        return r;
    endfunction

    task automatic run_op(input int o, input bit dy, input logic [W-1:0] s, input logic [W-1:0] d);
        string tag;
        bit es, eo;
        logic [W-1:0] er;
        er = exp_result(o, dy, s, d, tag, es, eo);
        @(negedge clk);
        start = 1'b1; op = 3'(o); dyadic = dy; src = s; dst = d;
        @(negedge clk);
        start = 1'b0;
        chk("R2 done", 32'(done), 32'd1);
        chk(tag, 32'(result), 32'(er));
        chk("R3 n", 32'(flag_n), 32'(er[W-1]));
        chk("R3 z", 32'(flag_z), 32'(er[W-2:0] == '0));
        chk("R4 inf", 32'(flag_inf), 32'((er[W-2:FW] == '1) && (er[FW-2:0] == '0)));
        chk("R4 nan", 32'(flag_nan), 32'((er[W-2:FW] == '1) && (er[FW-2:0] != '0)));
        chk("R8 wr", 32'(wr_en), 32'(o != 1));
        chk("R6 snan", 32'(snan), 32'(es));
        chk("R12 operr", 32'(operr), 32'(eo));
    endtask

    initial begin
        logic [W-1:0] dlist [8];
        logic [W-1:0] held;
        dlist[0] = 11'b0_1111_000001; // signaling NaN, integer bit clear
        dlist[1] = 11'b1_1111_110000; // quiet NaN
        dlist[2] = 11'b0_1111_100000; // infinity with integer bit set
        dlist[3] = 11'b1_1111_000000; // infinity, integer bit clear
        dlist[4] = 11'b0_0111_100000; // +1.0
        dlist[5] = 11'b1_0000_000000; // -0
        dlist[6] = 11'b0_1111_100111; // signaling NaN, integer bit set
        dlist[7] = 11'b0_0010_010101; // ordinary

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", 32'(done), 0);
        chk("R1 result", 32'(result), 0);
        chk("R1 flags", 32'({flag_n, flag_z, flag_inf, flag_nan}), 0);
        chk("R1 wr", 32'(wr_en), 0);
        chk("R1 status", 32'({snan, operr}), 0);

        // Monadic sweep: every op, every source; dst NaN-heavy but dyadic low (R5)
        for (int o = 0; o < 8; o++) begin
            for (int s = 0; s < (1 << W); s++) begin
                run_op(o, 1'b0, W'(s), W'(s) ^ 11'b0_1111_001010);
            end
        end

        // Dyadic sweep: every source against chosen destinations (R5, R6)
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < (1 << W); s++) begin
                run_op((s % 2 == 0) ? 0 : 4, 1'b1, W'(s), dlist[k]);
            end
        end

        // R2 hold: idle cycles with changing inputs leave outputs alone
        run_op(3, 1'b0, 11'b0_0101_101010, '0);
        held = result;
        @(negedge clk);
        op = 3'd2; src = 11'b1_1111_000000; dst = '1; dyadic = 1'b1;
        @(negedge clk);
        chk("R2 hold result", 32'(result), 32'(held));
        chk("R2 done low", 32'(done), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule